// File: doc/BRIEF.md
# Sync Word Clamp and Luma/Chroma Interleaver

This block sits at the front of a high-definition video transmit path. Each parallel-rate beat it captures a 20-bit input that holds a luma word in the upper half and a chroma word in the lower half. Every 10-bit word goes through a clamp that forces the two least significant bits when the eight upper bits are all zeros or all ones. Sources with only 8 bits of resolution therefore still produce the exact 10-bit timing-reference values 000h and 3FFh. A disable input turns the clamp off for payloads that are not video.

The block runs on a word clock at twice the parallel rate. A parallel-beat strobe marks the word-clock cycles that stand for a parallel clock edge. The two clamped words leave the block in two forms at once. The first is a 10-bit stream at word rate, chroma first and then luma, with a flag on the chroma word. The second is a 20-bit pair for a downstream serializer that takes both words in one beat. Scrambling, serialization and clock synthesis belong to other blocks.

Top module: `yc_sync_interleave`

## Requirements
- R1: While reset is asserted and after it is released, `word_o`, `pair_o` and `word_first_o` are all zero until the first latched input reaches the output.
- R2: With the clamp enabled, a word whose bits 9:2 are all zero (000h..003h) is output as 000h.
- R3: With the clamp enabled, a word whose bits 9:2 are all one (3FCh..3FFh) is output as 3FFh.
- R4: Any word whose bits 9:2 are neither all zero nor all one (for example 004h, 3FBh, 155h) is output unchanged.
- R5: When `clamp_off_i` is high in the same cycle as the strobe that captures the data, both words of that beat pass unchanged, including reserved values.
- R6: Luma is taken from `data_i[19:10]` and chroma from `data_i[9:0]`. Each half is clamped on its own, so a reserved value in one half never alters the other half.
- R7: On the word stream, the chroma word comes out first with `word_first_o` high. In the next word-clock cycle the luma word comes out with `word_first_o` low.
- R8: Data captured on a strobed edge reaches `word_o` and `pair_o` on the second strobed edge after that one, which is two parallel beats. `word_first_o` is never high one cycle earlier. The strobe must not be high in two consecutive cycles.
- R9: `pair_o` carries luma in bits 19:10 and chroma in bits 9:0. It updates on the same edge as the chroma word.
- R10: `word_first_o` is high for exactly one cycle per captured beat. Once the luma word has been sent and no strobe is present, `word_o` and `pair_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, twice the parallel beat rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en_i | input | 1 | Parallel-beat strobe, high on every other word-clock cycle |
| data_i | input | 20 | Luma in 19:10, chroma in 9:0 |
| clamp_off_i | input | 1 | High disables sync-word clamping for the beat being captured |
| word_o | output | 10 | Interleaved word stream, chroma then luma |
| word_first_o | output | 1 | Marks the chroma word of each pair on `word_o` |
| pair_o | output | 20 | Clamped pair, luma in 19:10, chroma in 9:0 |

## Verification
The clamp is tested with words just inside each reserved band (001h, 002h, 003h, 3FDh, 3FEh, 3FCh). It is also tested with the neighbours just outside the bands (004h, 3FBh) and with a mid-scale value. A wrong mask width or a swapped fill polarity therefore shows up as a specific mismatch. Mixed pairs with a reserved value in only one half show whether the halves are clamped independently and whether they are placed in the correct order. The same reserved values are then sent with the disable high, which separates clamping from plain passing. Two beats are sent back to back to confirm the chroma, luma, chroma, luma sequence and its latency. An idle stretch after the stream checks that the output holds its value.

// File: rtl/yc_sync_pkg.sv
package yc_sync_pkg;

    typedef enum logic [1:0] {
        RSV_NONE = 2'd0,
        RSV_LOW  = 2'd1,
        RSV_HIGH = 2'd2
    } rsv_kind_e;

    // Classify a word by its upper field against the two reserved bands
    function automatic rsv_kind_e classify_upper(input logic [31:0] upper, input int unsigned width);
        logic [31:0] ones;
        ones = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
        if ((upper & ones) == 32'd0)
            return RSV_LOW;
        else if ((upper & ones) == ones)
            return RSV_HIGH;
        else
            return RSV_NONE;
    endfunction

endpackage

// File: rtl/yc_sync_clamp.sv
module yc_sync_clamp #(
    parameter int WORD_W  = 10,
    parameter int GUARD_W = 2
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              bypass_i,
    output logic [WORD_W-1:0] word_o
);
    import yc_sync_pkg::*;

    localparam int UPPER_W = WORD_W - GUARD_W;

    logic [31:0] upper_ext;
    rsv_kind_e   kind;

    always_comb begin
        upper_ext = 32'(word_i[WORD_W-1:GUARD_W]);
        kind      = classify_upper(upper_ext, UPPER_W);
        word_o    = word_i;
        if (!bypass_i) begin
            case (kind)
                RSV_LOW:  word_o[GUARD_W-1:0] = '0;
                RSV_HIGH: word_o[GUARD_W-1:0] = '1;
                default:  word_o = word_i;
            endcase
        end
    end

endmodule

// File: rtl/yc_interleaver.sv
module yc_interleaver #(
    parameter int WORD_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_i,
    input  logic                vld_i,
    input  logic [2*WORD_W-1:0] pair_i,
    output logic [WORD_W-1:0]   word_o,
    output logic                first_o,
    output logic [2*WORD_W-1:0] pair_o
);
    localparam int PAIR_W = 2 * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              first;
        logic              pend;
        logic [PAIR_W-1:0] pair;
    } ilv_t;

    ilv_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.first = 1'b0;
        if (adv_i) begin
            st_d.pair  = pair_i;
            st_d.word  = pair_i[WORD_W-1:0];
            st_d.first = vld_i;
            st_d.pend  = vld_i;
        end else if (st_q.pend) begin
            st_d.word = st_q.pair[PAIR_W-1:WORD_W];
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign first_o = st_q.first;
    assign pair_o  = st_q.pair;

endmodule

// File: rtl/yc_sync_interleave.sv
module yc_sync_interleave #(
    parameter int WORD_W  = 10,
    parameter int GUARD_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en_i,
    input  logic [2*WORD_W-1:0] data_i,
    input  logic                clamp_off_i,
    output logic [WORD_W-1:0]   word_o,
    output logic                word_first_o,
    output logic [2*WORD_W-1:0] pair_o
);
    localparam int PAIR_W = 2 * WORD_W;
    localparam int LANES  = 2;

    typedef struct packed {
        logic [PAIR_W-1:0] cap;
        logic              off;
        logic              v1;
        logic [PAIR_W-1:0] cl;
        logic              v2;
    } pipe_t;

    pipe_t             st_d, st_q;
    logic [PAIR_W-1:0] clamped;

    // lane 0 = chroma (low half), lane 1 = luma (high half)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        yc_sync_clamp #(
            .WORD_W (WORD_W),
            .GUARD_W(GUARD_W)
        ) u_clamp (
            .word_i  (st_q.cap[g*WORD_W +: WORD_W]),
            .bypass_i(st_q.off),
            .word_o  (clamped[g*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        st_d = st_q;
        if (pix_en_i) begin
            st_d.cap = data_i;
            st_d.off = clamp_off_i;
            st_d.v1  = 1'b1;
            st_d.cl  = clamped;
            st_d.v2  = st_q.v1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    yc_interleaver #(
        .WORD_W(WORD_W)
    ) u_ilv (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (pix_en_i),
        .vld_i  (st_q.v2),
        .pair_i (st_q.cl),
        .word_o (word_o),
        .first_o(word_first_o),
        .pair_o (pair_o)
    );

endmodule

// File: rtl/yc_sync_interleave_chk.sv
module yc_sync_interleave_chk #(
    parameter int WORD_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pix_en_i,
    input logic [WORD_W-1:0]   word_o,
    input logic                word_first_o,
    input logic [2*WORD_W-1:0] pair_o
);
    // R7
    first_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_first_o |=> !word_first_o);

    // R7
    luma_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_first_o |=> (word_o == $past(pair_o[2*WORD_W-1:WORD_W])));

    // R9
    pair_matches_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_first_o |-> (pair_o[WORD_W-1:0] == word_o));

    // R8
    first_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_first_o |-> $past(pix_en_i));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en_i && !word_first_o) |=> ($stable(word_o) && $stable(pair_o)));

endmodule

bind yc_sync_interleave yc_sync_interleave_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en_i    (pix_en_i),
    .word_o      (word_o),
    .word_first_o(word_first_o),
    .pair_o      (pair_o)
);

// File: tb/tb_yc_sync_interleave.sv
module tb_yc_sync_interleave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en_i = 1'b0;
    logic [19:0] data_i = '0;
    logic        clamp_off_i = 1'b0;
    logic [9:0]  word_o;
    logic        word_first_o;
    logic [19:0] pair_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    yc_sync_interleave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en_i    (pix_en_i),
        .data_i      (data_i),
        .clamp_off_i (clamp_off_i),
        .word_o      (word_o),
        .word_first_o(word_first_o),
        .pair_o      (pair_o)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, return just after the following posedge
    task automatic step(input logic en, input logic [19:0] d, input logic off);
        @(negedge clk);
        pix_en_i    = en;
        data_i      = d;
        clamp_off_i = off;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [9:0] clampw(input logic [9:0] w, input logic off);
        if (off) return w;
        if (w[9:2] == 8'h00) return 10'h000;
        if (w[9:2] == 8'hFF) return 10'h3FF;
        return w;
    endfunction

    task automatic run_pair(input logic [9:0] y, input logic [9:0] c, input logic off, input string tag);
        logic [9:0] ey, ec;
        ey = clampw(y, off);
        ec = clampw(c, off);
        step(1'b1, {y, c}, off);
        step(1'b0, 20'h0, 1'b0);
        step(1'b1, 20'h0, 1'b0);
        step(1'b0, 20'h0, 1'b0);
        chk({tag, " R8 no early flag"}, {19'h0, word_first_o}, 20'h0);
        step(1'b1, 20'h0, 1'b0);
        chk({tag, " R7 chroma word"}, {10'h0, word_o}, {10'h0, ec});
        chk({tag, " R7 first flag"}, {19'h0, word_first_o}, 20'h1);
        chk({tag, " R9 pair"}, pair_o, {ey, ec});
        step(1'b0, 20'h0, 1'b0);
        chk({tag, " R7 luma word"}, {10'h0, word_o}, {10'h0, ey});
        chk({tag, " R10 flag low"}, {19'h0, word_first_o}, 20'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 word in reset", {10'h0, word_o}, 20'h0);
        chk("R1 pair in reset", pair_o, 20'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 20'hFFFFF, 1'b0);
        step(1'b0, 20'h0, 1'b0);
        chk("R1 flag after reset", {19'h0, word_first_o}, 20'h0);
        chk("R1 word after reset", {10'h0, word_o}, 20'h0);
        step(1'b1, 20'h0, 1'b0);
        chk("R1 flag before data", {19'h0, word_first_o}, 20'h0);
        step(1'b0, 20'h0, 1'b0);
    endtask

    task automatic t_low();
        run_pair(10'h002, 10'h001, 1'b0, "R2 low band");
        run_pair(10'h003, 10'h000, 1'b0, "R2 low band edge");
    endtask

    task automatic t_high();
        run_pair(10'h3FD, 10'h3FE, 1'b0, "R3 high band");
        run_pair(10'h3FC, 10'h3FF, 1'b0, "R3 high band edge");
    endtask

    task automatic t_pass();
        run_pair(10'h004, 10'h3FB, 1'b0, "R4 outside bands");
        run_pair(10'h155, 10'h2AA, 1'b0, "R4 mid scale");
    endtask

    task automatic t_mixed();
        run_pair(10'h003, 10'h123, 1'b0, "R6 luma only reserved");
        run_pair(10'h200, 10'h3FC, 1'b0, "R6 chroma only reserved");
    endtask

    task automatic t_off();
        run_pair(10'h002, 10'h3FD, 1'b1, "R5 disabled");
        chk("R5 raw chroma kept", pair_o, {10'h002, 10'h3FD});
    endtask

    task automatic t_stream();
        step(1'b1, {10'h001, 10'h3FE}, 1'b0);
        step(1'b0, 20'h0, 1'b0);
        step(1'b1, {10'h0F0, 10'h00F}, 1'b0);
        step(1'b0, 20'h0, 1'b0);
        step(1'b1, 20'h0, 1'b0);
        chk("R8 stream chroma A", {9'h0, word_first_o, word_o}, {9'h0, 1'b1, 10'h3FF});
        step(1'b0, 20'h0, 1'b0);
        chk("R7 stream luma A", {9'h0, word_first_o, word_o}, {9'h0, 1'b0, 10'h000});
        step(1'b1, 20'h0, 1'b0);
        chk("R8 stream chroma B", {9'h0, word_first_o, word_o}, {9'h0, 1'b1, 10'h00F});
        step(1'b0, 20'h0, 1'b0);
        chk("R7 stream luma B", {9'h0, word_first_o, word_o}, {9'h0, 1'b0, 10'h0F0});
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 20'hABCDE, 1'b0);
            chk("R10 idle word", {10'h0, word_o}, {10'h0, 10'h0F0});
            chk("R10 idle pair", pair_o, {10'h0F0, 10'h00F});
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_low();
        t_high();
        t_pass();
        t_mixed();
        t_off();
        t_stream();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule